// File: doc/BRIEF.md
# Funnel Shifter Unit

This block shifts or rotates an N-bit word by an amount k, where 0 <= k < N. Six kinds of shift are supported: logical left and right, arithmetic left and right, and rotate left and right. A 3-bit operation code picks the kind.

All six kinds use one datapath. A source word of 2N-1 bits is built from the input, with a fill pattern placed above or below it. An N-bit window is then cut from that source at an offset. The offset passes through log2(N) stages of 2:1 multiplexers, and each stage is steered directly by one offset bit.

For a right shift, the offset is k. For a left shift, the offset is N-1-k, which is the bitwise inverse of k, so no adder is needed. The result is registered, and it is valid one clock after the operands are presented.

Top module: `funsh_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `dout` becomes all zeros after that edge.
- R2: Operands sampled at one rising edge appear on `dout` after that edge. `dout` does not change between edges.
- R3: Op code 3'b000 (logical left) gives `din << k`, with the low k bits filled with 0.
- R4: Op code 3'b001 (logical right) gives `din >> k`, with the high k bits filled with 0.
- R5: Op code 3'b010 (arithmetic left) gives the same result as op code 3'b000.
- R6: Op code 3'b011 (arithmetic right) gives `din >> k`, with the high k bits filled with copies of `din[N-1]`.
- R7: Op code 3'b100 (rotate left) moves each bit i to position (i+k) mod N. No bit is lost, so the count of ones is preserved.
- R8: Op code 3'b101 (rotate right) moves each bit i to position (i-k) mod N. The count of ones is preserved.
- R9: When k = 0, every op code returns `din` unchanged.
- R10: Op codes 3'b110 and 3'b111 return `din` unchanged for any k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | N | Word to shift |
| shamt | input | log2(N) | Shift amount k |
| op | input | 3 | Operation code |
| dout | output | N | Registered result |

## Verification
Each result is due one rising edge after its operands are sampled. The bench therefore drives operands on a falling edge and compares `dout` on the next falling edge, half a cycle after the register has loaded.

One directed check looks at `dout` shortly after a new drive and before the following rising edge. It confirms that the old value is still held, which shows the output is registered. The bench steps through every op code, every k and every 8-bit value, then runs seeded random vectors. The expected value for each vector comes from plain shift expressions in the bench.

// File: rtl/funsh_pkg.sv
package funsh_pkg;
  typedef enum logic [2:0] {
    OP_LSL = 3'b000,
    OP_LSR = 3'b001,
    OP_ASL = 3'b010,
    OP_ASR = 3'b011,
    OP_ROL = 3'b100,
    OP_ROR = 3'b101,
    OP_NP6 = 3'b110,
    OP_NP7 = 3'b111
  } shop_e;
endpackage

// File: rtl/funsh_src.sv
// Builds the 2N-1 bit source word and the window offset for the selected op.
module funsh_src
  import funsh_pkg::*;
#(
  parameter int N    = 8,
  parameter int KW   = $clog2(N),
  parameter int SW   = 2*N-1
) (
  input  logic [N-1:0]  din,
  input  logic [KW-1:0] shamt,
  input  logic [2:0]    op,
  output logic [SW-1:0] src,
  output logic [KW-1:0] off
);
  localparam int FW = N-1;

  logic [FW-1:0] sign_fill;
  logic [FW-1:0] zero_fill;
  logic [FW-1:0] wrap_lo;
  logic [FW-1:0] wrap_hi;

  assign sign_fill = {FW{din[N-1]}};
  assign zero_fill = '0;
  assign wrap_lo   = din[N-1:1];
  assign wrap_hi   = din[N-2:0];

  always_comb begin
    src = {zero_fill, din};
    off = '0;
    unique case (shop_e'(op))
      OP_LSL, OP_ASL: begin
        src = {din, zero_fill};
        off = ~shamt;
      end
      OP_ROL: begin
        src = {din, wrap_lo};
        off = ~shamt;
      end
      OP_LSR: begin
        src = {zero_fill, din};
        off = shamt;
      end
      OP_ASR: begin
        src = {sign_fill, din};
        off = shamt;
      end
      OP_ROR: begin
        src = {wrap_hi, din};
        off = shamt;
      end
      default: begin
        src = {zero_fill, din};
        off = '0;
      end
    endcase
  end
endmodule

// File: rtl/funsh_window.sv
// Log-depth 2:1 mux chain picking an N-bit window at a given offset.
module funsh_window #(
  parameter int N  = 8,
  parameter int KW = $clog2(N),
  parameter int SW = 2*N-1
) (
  input  logic [SW-1:0] src,
  input  logic [KW-1:0] off,
  output logic [N-1:0]  win
);
  logic [SW-1:0] stage [0:KW];

  assign stage[0] = src;

  for (genvar s = 0; s < KW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = off[s] ? (stage[s] >> STEP) : stage[s];
  end

  assign win = stage[KW][N-1:0];
endmodule

// File: rtl/funsh_unit.sv
// Top: funnel shifter with registered output.
module funsh_unit #(
  parameter int N  = 8,
  parameter int KW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  din,
  input  logic [KW-1:0] shamt,
  input  logic [2:0]    op,
  output logic [N-1:0]  dout
);
  localparam int SW = 2*N-1;

  logic [SW-1:0] src_w;
  logic [KW-1:0] off_w;
  logic [N-1:0]  win_w;

  funsh_src #(.N(N), .KW(KW), .SW(SW)) src_i (
    .din   (din),
    .shamt (shamt),
    .op    (op),
    .src   (src_w),
    .off   (off_w)
  );

  funsh_window #(.N(N), .KW(KW), .SW(SW)) win_i (
    .src (src_w),
    .off (off_w),
    .win (win_w)
  );

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= win_w;
  end
endmodule

// File: rtl/funsh_chk.sv
module funsh_chk
  import funsh_pkg::*;
#(
  parameter int N  = 8,
  parameter int KW = $clog2(N)
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  din,
  input logic [KW-1:0] shamt,
  input logic [2:0]    op,
  input logic [N-1:0]  dout
);
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= !rst;

  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> dout == '0); // R1
  AST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (rst || !primed)
    $past(shamt) == '0 |-> dout == $past(din)); // R9
  AST_LSL_LOW_ZERO: assert property (@(posedge clk) disable iff (rst || !primed)
    ($past(op) == OP_LSL || $past(op) == OP_ASL) && $past(shamt) != '0 |-> dout[0] == 1'b0); // R3
  AST_LSR_TOP_ZERO: assert property (@(posedge clk) disable iff (rst || !primed)
    $past(op) == OP_LSR && $past(shamt) != '0 |-> dout[N-1] == 1'b0); // R4
  AST_ASR_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst || !primed)
    $past(op) == OP_ASR |-> dout[N-1] == $past(din[N-1])); // R6
  AST_ROT_ONES: assert property (@(posedge clk) disable iff (rst || !primed)
    ($past(op) == OP_ROL || $past(op) == OP_ROR) |-> $countones(dout) == $countones($past(din))); // R7 R8
  AST_NOP_PASS: assert property (@(posedge clk) disable iff (rst || !primed)
    ($past(op) == OP_NP6 || $past(op) == OP_NP7) |-> dout == $past(din)); // R10
endmodule

bind funsh_unit funsh_chk #(.N(N), .KW(KW)) chk_i (
  .clk(clk), .rst(rst), .din(din), .shamt(shamt), .op(op), .dout(dout)
);

// File: tb/funsh_unit_tb_top.sv
`timescale 1ns/1ps
module funsh_unit_tb_top;
  localparam int N  = 8;
  localparam int KW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  din = '0;
  logic [KW-1:0] shamt = '0;
  logic [2:0]    op = '0;
  logic [N-1:0]  dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  funsh_unit #(.N(N), .KW(KW)) dut_i (
    .clk(clk), .rst(rst), .din(din), .shamt(shamt), .op(op), .dout(dout)
  );

  function automatic logic [N-1:0] ref_shift(logic [N-1:0] a, int k, logic [2:0] o);
    logic [2*N-1:0] wide;
    case (o)
      3'b000, 3'b010: return a << k;
      3'b001:         return a >> k;
      3'b011:         return N'($signed(a) >>> k);
      3'b100: begin wide = {a, a} << k; return wide[2*N-1:N]; end
      3'b101: begin wide = {a, a} >> k; return wide[N-1:0]; end
      default:        return a;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] o);
    case (o)
      3'b000: return "R3";
      3'b001: return "R4";
      3'b010: return "R5";
      3'b011: return "R6";
      3'b100: return "R7";
      3'b101: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: dout=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic apply(logic [N-1:0] a, int k, logic [2:0] o, string tag);
    @(negedge clk);
    din = a; shamt = KW'(k); op = o;
    @(negedge clk);
    check(tag, dout, ref_shift(a, k, o));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    din = 8'hA5;
    @(negedge clk); @(negedge clk);
    check("R1", dout, '0);
    rst = 1'b0;

    // Directed examples from the requirements
    apply(8'b1000_1011, 1, 3'b011, "R6");
    check("R6", dout, 8'b1100_0101);
    apply(8'b1000_1011, 1, 3'b100, "R7");
    check("R7", dout, 8'b0001_0111);
    apply(8'b1000_1011, 1, 3'b101, "R8");
    check("R8", dout, 8'b1100_0101);

    // R2: output holds until the next rising edge
    @(negedge clk);
    din = 8'h0F; shamt = 3'd4; op = 3'b000;
    #0.5;
    check("R2", dout, 8'b1100_0101);
    @(negedge clk);
    check("R2", dout, 8'hF0);

    // R9: zero shift for every op
    for (int o = 0; o < 8; o++) apply(8'h96, 0, 3'(o), "R9");

    // Max shift corners
    apply(8'h80, N-1, 3'b011, "R6");
    apply(8'h01, N-1, 3'b000, "R3");
    apply(8'h81, N-1, 3'b100, "R7");

    // Exhaustive sweep of the six shifts
    for (int o = 0; o < 6; o++)
      for (int k = 0; k < N; k++)
        for (int a = 0; a < 256; a++)
          apply(8'(a), k, 3'(o), tag_of(3'(o)));

    // R5: arithmetic left equals logical left
    for (int k = 0; k < N; k++) apply(8'hC3, k, 3'b010, "R5");

    // Random mix including reserved codes
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 7));
      apply(8'($urandom), int'($urandom_range(0, N-1)), o, tag_of(o));
    end

    // R1: reset mid-stream
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", dout, '0);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: dout=%h expected=completion", dout);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule